// File: doc/BRIEF.md
# Even/Odd Byte-Lane Memory Front End

This block is the memory side of a 16-bit processor bus that addresses bytes. Storage is split into two byte-wide banks. One bank holds every even byte address and the other holds every odd byte address. Each bank is wired to a fixed half of the data bus. The even bank owns bits 7..0 and the odd bank owns bits 15..8.

On every cycle the block decodes two inputs into one enable per bank: the lowest address bit and an active-low high-half enable. From the result it performs a full word access, a single-byte access on either lane, or no access at all. Both banks use the same internal word index, which is the byte address with its lowest bit dropped.

Reads are synchronous. The data and a valid flag are registered and appear in the cycle after the read strobe is sampled. A decode that enables neither bank raises a one-cycle flag instead of doing anything. The processor splits misaligned words into two bus cycles, so the block never does this.

Top module: `evenodd_lane_mem`

## Requirements
- R1: With `addr[0]`=0 and `bhe_n`=0 (word), a write stores `wdata[7:0]` in the even bank and `wdata[15:8]` in the odd bank. A read returns the odd byte on `rdata[15:8]` and the even byte on `rdata[7:0]`.
- R2: With `addr[0]`=0 and `bhe_n`=1 (even byte), a write changes only the even bank and ignores `wdata[15:8]`. A read returns `rdata[15:8]`=8'h00 and the even byte on `rdata[7:0]`.
- R3: With `addr[0]`=1 and `bhe_n`=0 (odd byte), a write changes only the odd bank from `wdata[15:8]` and ignores `wdata[7:0]`. A read returns the odd byte on `rdata[15:8]` and `rdata[7:0]`=8'h00.
- R4: With `addr[0]`=1 and `bhe_n`=1, a read or write strobe changes neither bank and leaves `rvalid` low. In the next cycle it raises `bad_acc` for exactly one cycle.
- R5: The word index inside both banks is `addr[BANK_AW:1]`. Byte addresses 2k and 2k+1 share word k, and address bits above `BANK_AW` do not select storage.
- R6: `rvalid` and `rdata` change in the cycle after the clock edge that samples `rd` with a decode that enables at least one bank. `rvalid` is high for one cycle per sampled strobe, and `rdata` is 0 whenever `rvalid` is low.
- R7: When `rd` and `wr` are both sampled at the same edge for the same word, the read returns the contents from before that write, and the write takes effect.
- R8: While `rst_n` is low, `rvalid`, `bad_acc` and `rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the output registers |
| addr | input | ADDR_W (20) | Byte address |
| bhe_n | input | 1 | Active-low enable of the high byte lane |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 16 | Write data, even lane on bits 7..0 |
| rdata | output | 16 | Registered read data |
| rvalid | output | 1 | Read data valid, one cycle per read |
| bad_acc | output | 1 | One-cycle flag for an access with neither bank enabled |

## Verification
A read and a write can be sampled at the same edge. The same edge can also carry a lane decode that enables nothing, which collides with the validity and zero-fill rules for the read. The bench drives `rd` and `wr` together on one word with a new value. It expects the old contents on `rdata`, then reads the word again and expects the new value. In random traffic the bench mixes all four lane decodes with simultaneous strobes. Every cycle it compares `rdata`, `rvalid` and `bad_acc` with a byte-level model of both banks.

// File: rtl/lane_mem_pkg.sv
package lane_mem_pkg;

    localparam int LANE_W = 8;

    typedef enum logic [1:0] {
        ACC_WORD = 2'd0,
        ACC_EVEN = 2'd1,
        ACC_ODD  = 2'd2,
        ACC_NONE = 2'd3
    } acc_kind_e;

endpackage

// File: rtl/lane_decode.sv
module lane_decode
    import lane_mem_pkg::*;
(
    input  logic      a0,
    input  logic      bhe_n,
    output logic      en_even,
    output logic      en_odd,
    output acc_kind_e kind
);

    always_comb begin
        en_even = !a0;
        en_odd  = !bhe_n;
        unique case ({a0, bhe_n})
            2'b00:   kind = ACC_WORD;
            2'b01:   kind = ACC_EVEN;
            2'b10:   kind = ACC_ODD;
            default: kind = ACC_NONE;
        endcase
    end

endmodule

// File: rtl/byte_bank.sv
module byte_bank #(
    parameter int AW    = 8,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    idx,
    input  logic [WIDTH-1:0] wbyte,
    output logic [WIDTH-1:0] rbyte
);

    localparam int DEPTH = 1 << AW;

    logic [WIDTH-1:0] cells [DEPTH];

    // read sees contents before this edge's write
    assign rbyte = cells[idx];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[idx] <= wbyte;
        end
    end

endmodule

// File: rtl/evenodd_lane_mem.sv
module evenodd_lane_mem
    import lane_mem_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int BANK_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              bhe_n,
    input  logic              rd,
    input  logic              wr,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    output logic              rvalid,
    output logic              bad_acc
);

    localparam int NUM_BANKS = 2;
    localparam int BUS_W     = NUM_BANKS * LANE_W;

    typedef struct packed {
        logic [BUS_W-1:0] rdata;
        logic             rvalid;
        logic             bad;
    } out_state_t;

    logic                 en_even;
    logic                 en_odd;
    acc_kind_e            kind;
    logic [BANK_AW-1:0]   word_idx;
    logic [NUM_BANKS-1:0] bank_en;
    logic [LANE_W-1:0]    bank_rd [NUM_BANKS];
    out_state_t           st_d;
    out_state_t           st_q;

    lane_decode u_decode (
        .a0      (addr[0]),
        .bhe_n   (bhe_n),
        .en_even (en_even),
        .en_odd  (en_odd),
        .kind    (kind)
    );

    assign word_idx = addr[BANK_AW:1];
    assign bank_en  = {en_odd, en_even};

    // bank g owns data bits [g*8 +: 8]
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        byte_bank #(
            .AW    (BANK_AW),
            .WIDTH (LANE_W)
        ) u_bank (
            .clk   (clk),
            .we    (wr && bank_en[g]),
            .idx   (word_idx),
            .wbyte (wdata[g*LANE_W +: LANE_W]),
            .rbyte (bank_rd[g])
        );
    end

    always_comb begin
        st_d        = '0;
        st_d.bad    = (rd || wr) && (kind == ACC_NONE);
        st_d.rvalid = rd && (kind != ACC_NONE);
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (rd && bank_en[b]) begin
                st_d.rdata[b*LANE_W +: LANE_W] = bank_rd[b];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata   = st_q.rdata;
    assign rvalid  = st_q.rvalid;
    assign bad_acc = st_q.bad;

endmodule

// File: rtl/evenodd_lane_mem_chk.sv
module evenodd_lane_mem_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              bhe_n,
    input logic              rd,
    input logic              wr,
    input logic [15:0]       rdata,
    input logic              rvalid,
    input logic              bad_acc
);

    p_bad_raised_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd || wr) && addr[0] && bhe_n) |=> bad_acc);

    p_bad_not_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bad_acc |-> !rvalid);

    p_read_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !(addr[0] && bhe_n)) |=> rvalid);

    p_no_strobe_no_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> !rvalid);

    p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid |-> (rdata == 16'h0000));

    p_even_high_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && bhe_n) |=> (rdata[15:8] == 8'h00));

    p_odd_low_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr[0]) |=> (rdata[7:0] == 8'h00));

endmodule

bind evenodd_lane_mem evenodd_lane_mem_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .bhe_n   (bhe_n),
    .rd      (rd),
    .wr      (wr),
    .rdata   (rdata),
    .rvalid  (rvalid),
    .bad_acc (bad_acc)
);

// File: tb/evenodd_lane_mem_tb_top.sv
`timescale 1ns/1ps
module evenodd_lane_mem_tb_top;

    localparam int ADDR_W  = 20;
    localparam int BANK_AW = 8;
    localparam int WORDS   = 1 << BANK_AW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              bhe_n = 1'b1;
    logic              rd = 1'b0;
    logic              wr = 1'b0;
    logic [15:0]       wdata = '0;
    logic [15:0]       rdata;
    logic              rvalid;
    logic              bad_acc;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] m_even [WORDS];
    logic [7:0] m_odd  [WORDS];

    always #2.5 clk = ~clk;

    evenodd_lane_mem #(.ADDR_W(ADDR_W), .BANK_AW(BANK_AW)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .bhe_n   (bhe_n),
        .rd      (rd),
        .wr      (wr),
        .wdata   (wdata),
        .rdata   (rdata),
        .rvalid  (rvalid),
        .bad_acc (bad_acc)
    );

    task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(logic a0, logic hn);
        case ({a0, hn})
            2'b00:   return "R1";
            2'b01:   return "R2";
            2'b10:   return "R3";
            default: return "R4";
        endcase
    endfunction

    function automatic logic [15:0] exp_read(logic [ADDR_W-1:0] a, logic hn);
        logic [BANK_AW-1:0] i = a[BANK_AW:1];
        logic [15:0] v = 16'h0000;
        if (!a[0]) v[7:0]  = m_even[i];
        if (!hn)   v[15:8] = m_odd[i];
        return v;
    endfunction

    // Called at a falling edge; returns at the next falling edge.
    task automatic op(string req, logic [ADDR_W-1:0] a, logic hn, logic r, logic w,
                      logic [15:0] d);
        logic [15:0] e_data;
        logic        e_val;
        logic        e_bad;
        logic [BANK_AW-1:0] i = a[BANK_AW:1];
        string tag = (req == "") ? req_of(a[0], hn) : req;
        e_val  = r && !(a[0] && hn);
        e_data = e_val ? exp_read(a, hn) : 16'h0000;
        e_bad  = (r || w) && a[0] && hn;
        addr = a; bhe_n = hn; rd = r; wr = w; wdata = d;
        @(posedge clk);
        #1;
        check(tag, "rvalid", {15'd0, rvalid}, {15'd0, e_val});
        check(tag, "rdata", rdata, e_data);
        check(tag, "bad_acc", {15'd0, bad_acc}, {15'd0, e_bad});
        if (w && !a[0]) m_even[i] = d[7:0];
        if (w && !hn)   m_odd[i]  = d[15:8];
        @(negedge clk);
        rd = 1'b0; wr = 1'b0;
    endtask

    task automatic idle_check(string req);
        addr = '0; bhe_n = 1'b1; rd = 1'b0; wr = 1'b0;
        @(posedge clk);
        #1;
        check(req, "rvalid idle", {15'd0, rvalid}, 16'd0);
        check(req, "rdata idle", rdata, 16'd0);
        check(req, "bad_acc idle", {15'd0, bad_acc}, 16'd0);
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        // R8: reset state
        check("R8", "rvalid reset", {15'd0, rvalid}, 16'd0);
        check("R8", "rdata reset", rdata, 16'd0);
        check("R8", "bad_acc reset", {15'd0, bad_acc}, 16'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // fill every word through word writes (R1)
        for (int k = 0; k < WORDS; k++) begin
            op("R1", ADDR_W'(2 * k), 1'b0, 1'b0, 1'b1, 16'((k * 257) ^ 16'h5a3c));
        end

        // R1: word write then read
        op("R1", 20'h00010, 1'b0, 1'b0, 1'b1, 16'hBEEF);
        op("R1", 20'h00010, 1'b0, 1'b1, 1'b0, 16'h0000);
        // R2: even byte write, upper data ignored, odd lane untouched
        op("R2", 20'h00010, 1'b1, 1'b0, 1'b1, 16'hFFAA);
        op("R2", 20'h00010, 1'b0, 1'b1, 1'b0, 16'h0000);
        op("R2", 20'h00010, 1'b1, 1'b1, 1'b0, 16'h0000);
        // R3: odd byte write, lower data ignored, even lane untouched
        op("R3", 20'h00011, 1'b0, 1'b0, 1'b1, 16'h7733);
        op("R3", 20'h00010, 1'b0, 1'b1, 1'b0, 16'h0000);
        op("R3", 20'h00011, 1'b0, 1'b1, 1'b0, 16'h0000);
        // R4: no-op decode on write and read; word unchanged
        op("R4", 20'h00011, 1'b1, 1'b0, 1'b1, 16'h1234);
        op("R4", 20'h00010, 1'b0, 1'b1, 1'b0, 16'h0000);
        op("R4", 20'h00011, 1'b1, 1'b1, 1'b0, 16'h0000);
        idle_check("R4");
        // R5: shared word for 2k/2k+1, upper address bits alias
        op("R5", 20'h00204, 1'b0, 1'b0, 1'b1, 16'hC0DE);
        op("R5", 20'h00004, 1'b0, 1'b1, 1'b0, 16'h0000);
        op("R5", 20'hFFE05, 1'b0, 1'b1, 1'b0, 16'h0000);
        // R6: idle cycle after a read drops valid and data
        op("R6", 20'h00004, 1'b0, 1'b1, 1'b0, 16'h0000);
        idle_check("R6");
        // R7: read and write together return old data, then new data
        op("R7", 20'h00020, 1'b0, 1'b1, 1'b1, 16'hA55A);
        op("R7", 20'h00020, 1'b0, 1'b1, 1'b0, 16'h0000);
        op("R7", 20'h00021, 1'b0, 1'b1, 1'b1, 16'h3C00);
        op("R7", 20'h00020, 1'b0, 1'b1, 1'b0, 16'h0000);

        // random mix over all decodes and strobes
        for (int n = 0; n < 3000; n++) begin
            logic [ADDR_W-1:0] ra = ADDR_W'($urandom);
            logic [3:0] ctl = 4'($urandom);
            op("", ra, ctl[0], ctl[1], ctl[2], 16'($urandom));
            if (ctl[3] && ctl[2]) idle_check("R6");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule